// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Controller

This block runs enhanced parallel port address and data cycles for a host register bus. The host bus offers one access at a time: an offset, a direction, an access size and write data. Offsets 3 and 4 start peripheral cycles. Offset 3 runs a single address byte. Offset 4 runs one, two or four data bytes. A wide access is cut into byte cycles, and the least significant byte goes first. Offset 2 holds the control register, and offset 1 gives the sticky timeout flag.

Every byte cycle raises an address or data strobe toward the peripheral. The strobe stays high until the peripheral raises its ready line, or until a timeout counter set by a parameter runs out. A cycle starts only when the masked control register matches one exact pattern for that direction. If the pattern does not match, the access does nothing. A timed-out byte ends the access and sets the sticky flag. While a cycle runs, the host sees a busy signal and its requests are dropped.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: A peripheral access at offset 3 runs exactly one cycle on the address strobe, whatever the size. A peripheral access at offset 4 runs its cycles on the data strobe.
- R2: A write at offset 3 or 4 runs only when (control AND 0x2F) == 0x04. Otherwise it raises no strobe, drives no data and leaves the timeout flag unchanged.
- R3: A read at offset 3 or 4 runs only when (control AND 0x2F) == 0x24. Otherwise it raises no strobe and returns all ones for the access width.
- R4: The size field sets how many bytes an offset-4 access moves: 0 moves 1 byte, 1 moves 2 bytes, and 2 or 3 moves 4 bytes. The bytes go in little-endian order, lane 0 first. Read data is right-aligned, and the lanes above the width read as zero.
- R5: Each byte cycle keeps its strobe high until per_ready is seen high. A read byte is taken from per_ad_i on that same clock edge.
- R6: If per_ready stays low for TMO_CYCLES strobe cycles in a row, the byte fails. The strobe drops and the access ends with no further bytes. A failed read returns all ones for its width.
- R7: The timeout flag is status bit 0 at offset 1. It is set by any failed byte cycle. Only a status write with bit 0 = 1 clears it.
- R8: host_busy stays high from the cycle after a peripheral cycle is accepted until its completion. Requests made while busy are ignored. Every accepted access gives a one-cycle host_done with host_rdata.
- R9: The control register sits at offset 2, resets to 0x0C and reads back as written. A status read returns {7'b0, flag}, and the flag resets to 0.
- R10: At most one strobe is high at any time. per_ad_oe is high only during write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, taken when host_busy is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | Access size code (offset 4) |
| host_wdata | input | DATA_W | Write data |
| host_busy | output | 1 | Peripheral cycle in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data, valid with host_done |
| per_ad_o | output | 8 | Byte driven to the peripheral |
| per_ad_oe | output | 1 | Output enable for per_ad_o |
| per_ad_i | input | 8 | Byte from the peripheral |
| per_addr_stb | output | 1 | Address cycle strobe, active high |
| per_data_stb | output | 1 | Data cycle strobe, active high |
| per_write | output | 1 | Cycle direction, 1 = write |
| per_ready | input | 1 | Peripheral ready, active high |

## Verification
Two faults show up first at the peripheral pins. A wrong byte index or a wrong last-lane value gives a wrong strobe count, or a swapped byte, in the very access where it happens. A gate decode error raises a strobe under a control value that should block it, and this shows within two cycles of the request. A timeout counter that is off by one makes the strobe hold for the wrong number of cycles. A flag that fails to set or clear shows up on the next status read. A busy or hold-off fault shows as a control value that changes during an access, or as a missing or repeated done pulse.

// File: rtl/epp_pkg.sv
package epp_pkg;

    localparam logic [2:0] OFS_STATUS  = 3'd1;
    localparam logic [2:0] OFS_CONTROL = 3'd2;
    localparam logic [2:0] OFS_ADDR    = 3'd3;
    localparam logic [2:0] OFS_DATA    = 3'd4;

    localparam logic [7:0] CTL_DIR   = 8'h20;
    localparam logic [7:0] CTL_SEL   = 8'h08;
    localparam logic [7:0] CTL_INIT  = 8'h04;
    localparam logic [7:0] CTL_ALF   = 8'h02;
    localparam logic [7:0] CTL_STB   = 8'h01;
    localparam logic [7:0] CTL_MASK  = CTL_DIR | CTL_SEL | CTL_INIT | CTL_ALF | CTL_STB;
    localparam logic [7:0] CTL_RESET = CTL_SEL | CTL_INIT;
    localparam logic [7:0] CTL_WR_OK = CTL_INIT;
    localparam logic [7:0] CTL_RD_OK = CTL_DIR | CTL_INIT;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_STROBE  = 2'd1,
        PH_RELEASE = 2'd2
    } phy_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/epp_gate.sv
module epp_gate
    import epp_pkg::*;
(
    input  logic [7:0] ctrl_i,
    output logic       wr_ok_o,
    output logic       rd_ok_o
);
    logic [7:0] masked;

    always_comb begin
        masked  = ctrl_i & CTL_MASK;
        wr_ok_o = (masked == CTL_WR_OK);
        rd_ok_o = (masked == CTL_RD_OK);
    end
endmodule

// File: rtl/epp_lane_mux.sv
module epp_lane_mux #(
    parameter  int unsigned LANES = 4,
    localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned W     = LANES * 8
) (
    input  logic [W-1:0]     word_i,
    input  logic [IDX_W-1:0] sel_i,
    input  logic [IDX_W-1:0] last_i,
    input  logic [W-1:0]     acc_i,
    input  logic [7:0]       byte_i,
    output logic [7:0]       byte_o,
    output logic [W-1:0]     acc_o,
    output logic [W-1:0]     mask_o
);
    logic [7:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g]          = word_i[g*8 +: 8];
        assign acc_o[g*8 +: 8]  = (sel_i == IDX_W'(g)) ? byte_i : acc_i[g*8 +: 8];
        assign mask_o[g*8 +: 8] = (IDX_W'(g) <= last_i) ? 8'hFF : 8'h00;
    end

    assign byte_o = lane[sel_i];
endmodule

// File: rtl/epp_strobe_phy.sv
module epp_strobe_phy
    import epp_pkg::*;
#(
    parameter  int unsigned TMO_CYCLES = 64,
    localparam int unsigned CNT_W      = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       is_addr_i,
    input  logic       is_write_i,
    input  logic [7:0] wbyte_i,
    input  logic       per_ready,
    input  logic [7:0] per_ad_i,
    output logic       per_addr_stb,
    output logic       per_data_stb,
    output logic       per_write,
    output logic       per_ad_oe,
    output logic [7:0] per_ad_o,
    output logic       fin_o,
    output logic       ok_o,
    output logic [7:0] rbyte_o
);
    typedef struct packed {
        phy_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             is_addr;
        logic             is_write;
        logic [7:0]       wbyte;
        logic [7:0]       rbyte;
        logic             ok;
    } phy_t;

    phy_t d, q;

    always_comb begin
        d = q;
        unique case (q.state)
            PH_IDLE: begin
                if (start_i) begin
                    d.state    = PH_STROBE;
                    d.cnt      = '0;
                    d.is_addr  = is_addr_i;
                    d.is_write = is_write_i;
                    d.wbyte    = wbyte_i;
                    d.ok       = 1'b0;
                end
            end
            PH_STROBE: begin
                if (per_ready) begin
                    d.ok    = 1'b1;
                    d.state = PH_RELEASE;
                    if (!q.is_write) begin
                        d.rbyte = per_ad_i;
                    end
                end else if (q.cnt == CNT_W'(TMO_CYCLES - 1)) begin
                    d.ok    = 1'b0;
                    d.state = PH_RELEASE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_RELEASE: d.state = PH_IDLE;
            default:    d.state = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: PH_IDLE, cnt: '0, is_addr: 1'b0, is_write: 1'b0,
                   wbyte: 8'h00, rbyte: 8'h00, ok: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign per_addr_stb = (q.state == PH_STROBE) && q.is_addr;
    assign per_data_stb = (q.state == PH_STROBE) && !q.is_addr;
    assign per_write    = (q.state != PH_IDLE) && q.is_write;
    assign per_ad_oe    = (q.state != PH_IDLE) && q.is_write;
    assign per_ad_o     = q.wbyte;
    assign fin_o        = (q.state == PH_RELEASE);
    assign ok_o         = q.ok;
    assign rbyte_o      = q.rbyte;
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
    import epp_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned TMO_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [1:0]        host_size,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [7:0]        per_ad_o,
    output logic              per_ad_oe,
    input  logic [7:0]        per_ad_i,
    output logic              per_addr_stb,
    output logic              per_data_stb,
    output logic              per_write,
    input  logic              per_ready
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        seq_state_e        state;
        logic              we;
        logic              is_addr;
        logic [IDX_W-1:0]  last;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] acc;
        logic              tmo;
        logic [7:0]        ctrl;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t d, q;

    logic              wr_ok, rd_ok;
    logic [7:0]        cur_byte;
    logic [DATA_W-1:0] acc_merged;
    logic [DATA_W-1:0] width_mask;
    logic              phy_start, phy_fin, phy_ok;
    logic [7:0]        phy_rbyte;
    logic [IDX_W-1:0]  req_last;
    logic [7:0]        ctrl_cur;
    logic              tmo_cur;

    epp_gate u_gate (
        .ctrl_i  (q.ctrl),
        .wr_ok_o (wr_ok),
        .rd_ok_o (rd_ok)
    );

    epp_lane_mux #(.LANES(LANES)) u_lanes (
        .word_i (q.wdata),
        .sel_i  (q.idx),
        .last_i (q.last),
        .acc_i  (q.acc),
        .byte_i (phy_rbyte),
        .byte_o (cur_byte),
        .acc_o  (acc_merged),
        .mask_o (width_mask)
    );

    epp_strobe_phy #(.TMO_CYCLES(TMO_CYCLES)) u_phy (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (phy_start),
        .is_addr_i    (q.is_addr),
        .is_write_i   (q.we),
        .wbyte_i      (cur_byte),
        .per_ready    (per_ready),
        .per_ad_i     (per_ad_i),
        .per_addr_stb (per_addr_stb),
        .per_data_stb (per_data_stb),
        .per_write    (per_write),
        .per_ad_oe    (per_ad_oe),
        .per_ad_o     (per_ad_o),
        .fin_o        (phy_fin),
        .ok_o         (phy_ok),
        .rbyte_o      (phy_rbyte)
    );

    // size code to index of the last byte lane; the address offset is always one byte
    always_comb begin
        if (host_addr == OFS_ADDR) begin
            req_last = '0;
        end else begin
            unique case (size_e'(host_size))
                SZ_BYTE: req_last = '0;
                SZ_HALF: req_last = IDX_W'(1);
                default: req_last = IDX_W'(LANES - 1);
            endcase
        end
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            SQ_IDLE: begin
                if (host_req) begin
                    d.rdata = '0;
                    unique case (host_addr)
                        OFS_STATUS: begin
                            d.done = 1'b1;
                            if (host_we) begin
                                if (host_wdata[0]) d.tmo = 1'b0;
                            end else begin
                                d.rdata = DATA_W'(q.tmo);
                            end
                        end
                        OFS_CONTROL: begin
                            d.done = 1'b1;
                            if (host_we) d.ctrl  = host_wdata[7:0];
                            else         d.rdata = DATA_W'(q.ctrl);
                        end
                        OFS_ADDR, OFS_DATA: begin
                            d.we      = host_we;
                            d.is_addr = (host_addr == OFS_ADDR);
                            d.last    = req_last;
                            d.idx     = '0;
                            d.wdata   = host_wdata;
                            d.acc     = '0;
                            if (host_we ? wr_ok : rd_ok) begin
                                d.state = SQ_ISSUE;
                            end else begin
                                d.done = 1'b1;
                                if (!host_we) d.rdata = ~(~'0 << (8 * (int'(req_last) + 1)));
                            end
                        end
                        default: d.done = 1'b1;
                    endcase
                end
            end
            SQ_ISSUE: d.state = SQ_WAIT;
            SQ_WAIT: begin
                if (phy_fin) begin
                    if (!phy_ok) begin
                        d.tmo   = 1'b1;
                        d.done  = 1'b1;
                        d.rdata = q.we ? '0 : width_mask;
                        d.state = SQ_IDLE;
                    end else begin
                        d.acc = acc_merged;
                        if (q.idx == q.last) begin
                            d.done  = 1'b1;
                            d.rdata = q.we ? '0 : acc_merged;
                            d.state = SQ_IDLE;
                        end else begin
                            d.idx   = q.idx + 1'b1;
                            d.state = SQ_ISSUE;
                        end
                    end
                end
            end
            default: d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SQ_IDLE, we: 1'b0, is_addr: 1'b0, last: '0, idx: '0,
                   wdata: '0, acc: '0, tmo: 1'b0, ctrl: CTL_RESET, done: 1'b0,
                   rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign phy_start  = (q.state == SQ_ISSUE);
    assign host_busy  = (q.state != SQ_IDLE);
    assign host_done  = q.done;
    assign host_rdata = q.rdata;
    assign ctrl_cur   = q.ctrl;
    assign tmo_cur    = q.tmo;
endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk #(
    parameter int unsigned TMO_CYCLES = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_req,
    input logic        host_we,
    input logic [2:0]  host_addr,
    input logic        host_wdata0,
    input logic        host_busy,
    input logic        per_addr_stb,
    input logic        per_data_stb,
    input logic        per_write,
    input logic        per_ad_oe,
    input logic [7:0]  ctrl_cur,
    input logic        tmo_cur
);
    logic        stb_any;
    logic [31:0] run_len;

    assign stb_any = per_addr_stb | per_data_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_len <= '0;
        else if (stb_any) run_len <= run_len + 1;
        else              run_len <= '0;
    end

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(per_addr_stb && per_data_stb));

    assert_oe_write_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        per_ad_oe |-> per_write);

    assert_write_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stb_any) && per_write) |-> ((ctrl_cur & 8'h2F) == 8'h04));

    assert_read_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stb_any) && !per_write) |-> ((ctrl_cur & 8'h2F) == 8'h24));

    assert_strobe_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= TMO_CYCLES);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_busy && host_we && host_addr == 3'd1 && host_wdata0) |=> !tmo_cur);

    assert_flag_set_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_cur) |-> $past(host_busy));

    assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stb_any |-> host_busy);

    assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |=> $stable(ctrl_cur));
endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req     (host_req),
    .host_we      (host_we),
    .host_addr    (host_addr),
    .host_wdata0  (host_wdata[0]),
    .host_busy    (host_busy),
    .per_addr_stb (per_addr_stb),
    .per_data_stb (per_data_stb),
    .per_write    (per_write),
    .per_ad_oe    (per_ad_oe),
    .ctrl_cur     (ctrl_cur),
    .tmo_cur      (tmo_cur)
);

// File: tb/test_epp_cycle_ctrl.sv
module test_epp_cycle_ctrl;
    localparam int unsigned DW  = 32;
    localparam int unsigned TMO = 16;
    localparam int unsigned DLY = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0, host_we = 1'b0;
    logic [2:0]    host_addr = '0;
    logic [1:0]    host_size = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_busy, host_done;
    logic [DW-1:0] host_rdata;
    logic [7:0]    per_ad_o, per_ad_i;
    logic          per_ad_oe, per_addr_stb, per_data_stb, per_write;
    logic          per_ready;

    always #2 clk = ~clk;

    epp_cycle_ctrl #(.DATA_W(DW), .TMO_CYCLES(TMO)) i_epp_cycle_ctrl (.*);

    // peripheral model
    logic [7:0]  rbase = 8'h00;
    logic [2:0]  rlim  = 3'd4;
    logic [2:0]  pidx, nstb;
    logic [63:0] wacc;
    logic        saw_a, saw_d, stb_prev;
    logic [7:0]  wcnt;
    int          run, maxrun, pin_err;
    logic        stb;

    assign stb      = per_addr_stb | per_data_stb;
    assign per_ad_i = rbase + 8'(pidx);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pidx <= '0; nstb <= '0; wacc <= '0; saw_a <= 1'b0; saw_d <= 1'b0;
            stb_prev <= 1'b0; wcnt <= '0; per_ready <= 1'b0; run <= 0; maxrun <= 0;
            pin_err <= 0;
        end else begin
            stb_prev <= stb;
            if ((per_addr_stb && per_data_stb) || (per_ad_oe && !per_write)) pin_err <= pin_err + 1;
            if (host_req && !host_busy) begin
                pidx <= '0; nstb <= '0; wacc <= '0; saw_a <= 1'b0; saw_d <= 1'b0;
                maxrun <= 0;
            end else begin
                if (stb && !stb_prev) begin
                    nstb <= nstb + 1'b1;
                    if (per_addr_stb) saw_a <= 1'b1;
                    if (per_data_stb) saw_d <= 1'b1;
                end
                if (stb) begin
                    run <= run + 1;
                    if (run + 1 > maxrun) maxrun <= run + 1;
                    if (!per_ready && wcnt >= 8'(DLY) && pidx < rlim) begin
                        per_ready <= 1'b1;
                        if (per_write) wacc[8*pidx +: 8] <= per_ad_o;
                    end
                    wcnt <= wcnt + 1'b1;
                end else begin
                    run <= 0;
                    wcnt <= '0;
                    per_ready <= 1'b0;
                    if (per_ready) pidx <= pidx + 1'b1;
                end
            end
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [2:0] ofs, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        while (host_busy) @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = ofs; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        while (!host_done) @(negedge clk);
        rd = host_rdata;
    endtask

    typedef struct packed {
        logic [7:0]  ctrl;
        logic        we;
        logic [2:0]  ofs;
        logic [1:0]  sz;
        logic [31:0] wd;
        logic [7:0]  rb;
        logic [2:0]  rl;
        logic [31:0] ev;
        logic [2:0]  ens;
        logic        ea;
        logic        et;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'h04, 1'b1, 3'd4, 2'd0, 32'h0000005A, 8'h00, 3'd4, 32'h0000005A, 3'd1, 1'b0, 1'b0},
        '{8'h04, 1'b1, 3'd3, 2'd0, 32'h000000C3, 8'h00, 3'd4, 32'h000000C3, 3'd1, 1'b1, 1'b0},
        '{8'h04, 1'b1, 3'd4, 2'd1, 32'h00001234, 8'h00, 3'd4, 32'h00001234, 3'd2, 1'b0, 1'b0},
        '{8'h04, 1'b1, 3'd4, 2'd2, 32'hDEADBEEF, 8'h00, 3'd4, 32'hDEADBEEF, 3'd4, 1'b0, 1'b0},
        '{8'h24, 1'b0, 3'd4, 2'd0, 32'h00000000, 8'h40, 3'd4, 32'h00000040, 3'd1, 1'b0, 1'b0},
        '{8'h24, 1'b0, 3'd4, 2'd1, 32'h00000000, 8'h10, 3'd4, 32'h00001110, 3'd2, 1'b0, 1'b0},
        '{8'h24, 1'b0, 3'd4, 2'd2, 32'h00000000, 8'h80, 3'd4, 32'h83828180, 3'd4, 1'b0, 1'b0},
        '{8'h24, 1'b0, 3'd3, 2'd0, 32'h00000000, 8'h77, 3'd4, 32'h00000077, 3'd1, 1'b1, 1'b0},
        '{8'h0C, 1'b1, 3'd4, 2'd2, 32'hAABBCCDD, 8'h00, 3'd4, 32'h00000000, 3'd0, 1'b0, 1'b0},
        '{8'h04, 1'b0, 3'd4, 2'd1, 32'h00000000, 8'h00, 3'd4, 32'h0000FFFF, 3'd0, 1'b0, 1'b0},
        '{8'h24, 1'b1, 3'd4, 2'd0, 32'h00000099, 8'h00, 3'd4, 32'h00000000, 3'd0, 1'b0, 1'b0},
        '{8'h25, 1'b0, 3'd4, 2'd0, 32'h00000000, 8'h00, 3'd4, 32'h000000FF, 3'd0, 1'b0, 1'b0},
        '{8'hD4, 1'b1, 3'd4, 2'd0, 32'h00000066, 8'h00, 3'd4, 32'h00000066, 3'd1, 1'b0, 1'b0},
        '{8'h24, 1'b0, 3'd4, 2'd2, 32'h00000000, 8'h00, 3'd0, 32'hFFFFFFFF, 3'd1, 1'b0, 1'b1},
        '{8'h04, 1'b1, 3'd4, 2'd2, 32'hCAFEF00D, 8'h00, 3'd1, 32'h0000000D, 3'd2, 1'b0, 1'b1},
        '{8'h24, 1'b0, 3'd4, 2'd1, 32'h00000000, 8'h20, 3'd1, 32'h0000FFFF, 3'd2, 1'b0, 1'b1},
        '{8'h04, 1'b1, 3'd3, 2'd2, 32'h11223344, 8'h00, 3'd4, 32'h00000044, 3'd1, 1'b1, 1'b0},
        '{8'h04, 1'b1, 3'd4, 2'd3, 32'h01020304, 8'h00, 3'd4, 32'h01020304, 3'd4, 1'b0, 1'b0}
    };

    function automatic string tag_of(input vec_t v);
        if (v.ens == 3'd0)                    return v.we ? "R2" : "R3";
        if (v.et)                             return "R6";
        if (v.ofs == 3'd4 && v.sz != 2'd0)    return "R4";
        if (v.ofs == 3'd3)                    return "R1";
        return "R5";
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R8 busy after reset", 32'(host_busy), 32'd0);
        chk("R8 done after reset", 32'(host_done), 32'd0);
        chk("R10 strobes after reset", 32'({per_addr_stb, per_data_stb, per_ad_oe}), 32'd0);
        acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
        chk("R9 status reset", rd, 32'h0);
        acc(1'b0, 3'd2, 2'd0, 32'h0, rd);
        chk("R9 control reset", rd, 32'h0000000C);

        // vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VECS[i];
            t = tag_of(v);
            acc(1'b1, 3'd2, 2'd0, 32'(v.ctrl), rd);
            acc(1'b1, 3'd1, 2'd0, 32'h1, rd);
            rbase = v.rb;
            rlim  = v.rl;
            acc(v.we, v.ofs, v.sz, v.wd, rd);
            @(negedge clk);
            if (v.we) chk({t, " write bytes"}, wacc[31:0], v.ev);
            else      chk({t, " read data"}, rd, v.ev);
            chk({t, " strobe count"}, 32'(nstb), 32'(v.ens));
            if (v.ens != 3'd0) chk({t, " R1 strobe kind"}, 32'({saw_a, saw_d}), 32'({v.ea, !v.ea}));
            if (v.et) chk("R6 strobe held", 32'(maxrun), 32'(TMO));
            acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
            chk({t, " R7 flag"}, rd, 32'(v.et));
        end

        // sticky flag: survives good access and a write with bit 0 clear
        rlim = 3'd0;
        acc(1'b1, 3'd2, 2'd0, 32'h24, rd);
        acc(1'b0, 3'd4, 2'd0, 32'h0, rd);
        rlim = 3'd4;
        acc(1'b0, 3'd4, 2'd0, 32'h0, rd);
        acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
        chk("R7 flag sticky over good access", rd, 32'h1);
        acc(1'b1, 3'd1, 2'd0, 32'hFE, rd);
        acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
        chk("R7 flag kept on bit0 clear write", rd, 32'h1);
        acc(1'b1, 3'd1, 2'd0, 32'h1, rd);
        acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
        chk("R7 flag cleared", rd, 32'h0);

        // hold-off while busy
        acc(1'b1, 3'd2, 2'd0, 32'h04, rd);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 3'd4; host_size = 2'd2; host_wdata = 32'h55667788;
        @(negedge clk);
        chk("R8 busy during access", 32'(host_busy), 32'd1);
        host_addr = 3'd2; host_size = 2'd0; host_wdata = 32'h0;
        @(negedge clk);
        host_req = 1'b0;
        while (!host_done) @(negedge clk);
        @(negedge clk);
        chk("R8 done single pulse", 32'(host_done), 32'd0);
        chk("R4 bytes of held-off access", wacc[31:0], 32'h55667788);
        acc(1'b0, 3'd2, 2'd0, 32'h0, rd);
        chk("R8 request while busy ignored", rd, 32'h04);
        acc(1'b1, 3'd2, 2'd0, 32'hA5, rd);
        acc(1'b0, 3'd2, 2'd0, 32'h0, rd);
        chk("R9 control readback", rd, 32'hA5);

        chk("R10 pin rule violations", 32'(pin_err), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule